// File: doc/BRIEF.md
# Reloading 16-bit Interval Timer

This block is a down-counting interval timer with a 16-bit counter and a 16-bit reload latch. Software reaches it over a byte-wide register port with four byte addresses: the low and high byte of the counter, and the low and high byte of the latch. The counter steps down once for each clock cycle on which the `tick` enable is high, so the count rate is set apart from the bus clock.

When the counter reaches zero, the block raises an interrupt flag. On the next tick the counter goes to all ones, and on the tick after that it reloads from the latch, so a full period is the latch value plus two ticks. In free-running mode every period raises the flag again. In one-shot mode only the first zero after the counter is loaded raises it. Which address a write goes to decides whether the counter is loaded and whether the flag is cleared.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous reset the counter and the latch both hold 0xFFFF, `irq_flag` is 0 and `rdata` is 0x00.
- R2: `addr` bit 0 selects the byte (0 = low, 1 = high) and `addr` bit 1 selects the register (0 = counter, 1 = latch). A write to address 0 or 2 changes only the low latch byte and leaves the counter alone.
- R3: A write to address 1 stores the high latch byte, loads the whole counter with {written byte, low latch byte} and clears `irq_flag`, all visible on the next cycle.
- R4: A write to address 3 stores the high latch byte and clears `irq_flag` on the next cycle, and it does not change the counter.
- R5: On each tick the counter decrements. A tick at zero gives 0xFFFF, and the tick after that reloads the latch, so one period lasts latch+2 ticks.
- R6: On a cycle with `tick` low and no write to address 1, the counter holds its value.
- R7: `irq_flag` is set on the same edge at which the counter becomes zero by a tick. With `free_run`=1 this happens again in every period.
- R8: With `free_run`=0, only the first zero after a write to address 1 sets `irq_flag`. Later zero crossings leave it clear.
- R9: A read strobe puts the selected byte on `rdata` one cycle later: the live counter bytes at addresses 0 and 1, and the stored latch bytes at addresses 2 and 3. A read at address 0 also clears `irq_flag`, and a read at address 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| free_run | input | 1 | 1 = reload and flag every period, 0 = one-shot flag |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Byte address (bit 0 = high byte, bit 1 = latch) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_flag | output | 1 | Registered timer interrupt flag |

## Verification
Every result is due exactly one clock edge after its cause. A write changes the latch, counter and flag at the next edge. A tick moves the counter and may set the flag at that same edge. Read data appears on `rdata` after the edge that sampled `rd_en`. The bench drives and samples on the falling edge, so each check reads the value settled after the single edge in question. It counts tick edges exactly to place the latch+2 period and the one-shot silence.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  // bit 0 selects the byte lane, bit 1 selects counter (0) or latch (1)
  typedef enum logic [1:0] {
    ADR_CTR_LO = 2'd0,
    ADR_CTR_HI = 2'd1,
    ADR_LAT_LO = 2'd2,
    ADR_LAT_HI = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/reload_timer_latch.sv
module reload_timer_latch #(
  parameter int BYTE_W = 8,
  localparam int LANES = 2,
  localparam int CNT_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  latch_q
);
  // counter and latch addresses of one lane both write that lane of the latch
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        latch_q[i*BYTE_W +: BYTE_W] <= '1;
      else if (wr_en && (addr[0] == i[0]))
        latch_q[i*BYTE_W +: BYTE_W] <= wdata;
    end
  end
endmodule

// File: rtl/reload_timer_count.sv
module reload_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] latch_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_q,
  output logic             zero_hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // wrap_q marks the all-ones step that precedes a reload
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      wrap_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      wrap_q <= 1'b0;
    end else if (tick) begin
      if (wrap_q) begin
        cnt_q  <= latch_q;
        wrap_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - ONE;
        wrap_q <= (cnt_q == '0);
      end
    end
  end

  // counter becomes zero on this edge through counting
  always_comb begin
    zero_hit = 1'b0;
    if (tick && !load)
      zero_hit = wrap_q ? (latch_q == '0) : (cnt_q == ONE);
  end
endmodule

// File: rtl/reload_timer_flag.sv
module reload_timer_flag (
  input  logic clk,
  input  logic rst,
  input  logic free_run,
  input  logic arm,
  input  logic zero_hit,
  input  logic clr,
  output logic irq_flag
);
  logic armed_q;

  // a set event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag <= 1'b0;
      armed_q  <= 1'b0;
    end else if (arm) begin
      irq_flag <= 1'b0;
      armed_q  <= 1'b1;
    end else begin
      if (zero_hit && (free_run || armed_q))
        irq_flag <= 1'b1;
      else if (clr)
        irq_flag <= 1'b0;
      if (zero_hit)
        armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              free_run,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq_flag
);
  import reload_timer_pkg::*;

  tmr_addr_e         sel;
  logic [CNT_W-1:0]  latch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  rd_src;
  logic              wrap_q;
  logic              zero_hit;
  logic              load;
  logic              clr;

  assign sel      = tmr_addr_e'(addr);
  assign load     = wr_en && (sel == ADR_CTR_HI);
  assign load_val = {wdata, latch_q[BYTE_W-1:0]};
  assign clr      = (wr_en && (sel == ADR_LAT_HI)) || (rd_en && (sel == ADR_CTR_LO));

  reload_timer_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .latch_q(latch_q)
  );

  reload_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(load_val),
    .latch_q(latch_q), .cnt_q(cnt_q), .wrap_q(wrap_q), .zero_hit(zero_hit)
  );

  reload_timer_flag u_flag (
    .clk(clk), .rst(rst), .free_run(free_run), .arm(load),
    .zero_hit(zero_hit), .clr(clr), .irq_flag(irq_flag)
  );

  assign rd_src = addr[1] ? latch_q : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= addr[0] ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
  end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              free_run,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [BYTE_W-1:0] wdata,
  input logic              irq_flag,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  latch,
  input logic              wrap
);
  logic ld;
  assign ld = wr_en && (addr == 2'd1);

  a_r3_load_counter: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == {$past(wdata), $past(latch[BYTE_W-1:0])}));

  a_r3_load_clears: assert property (@(posedge clk) disable iff (rst)
    ld |=> !irq_flag);

  a_r4_latch_hi_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3 && !tick) |=> (!irq_flag && $stable(cnt)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt));

  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && wrap && !ld) |=> (cnt == $past(latch)));

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap && cnt == CNT_W'(1) && free_run && !ld) |=> irq_flag);
endmodule

bind reload_timer reload_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .free_run(free_run), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .irq_flag(irq_flag),
  .cnt(cnt_q), .latch(latch_q), .wrap(wrap_q)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       free_run = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_flag;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  reload_timer u_reload_timer (
    .clk(clk), .rst(rst), .tick(tick), .free_run(free_run), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_flag(irq_flag)
  );

  // {write(1)/read(0), addr, write data or expected read data}
  localparam logic [10:0] VEC [0:10] = '{
    {1'b1, 2'd0, 8'h34},  // R2 counter-low write hits latch low
    {1'b0, 2'd2, 8'h34},  // R9 latch low read
    {1'b0, 2'd0, 8'hFF},  // R2 counter untouched
    {1'b1, 2'd3, 8'h12},  // R4 latch high write
    {1'b0, 2'd3, 8'h12},  // R9 latch high read
    {1'b0, 2'd1, 8'hFF},  // R4 no reload
    {1'b1, 2'd1, 8'h56},  // R3 load counter
    {1'b0, 2'd0, 8'h34},  // R3 counter low
    {1'b0, 2'd1, 8'h56},  // R3 counter high
    {1'b1, 2'd2, 8'h78},  // R2 latch-low write
    {1'b0, 2'd0, 8'h34}   // R2 counter unchanged
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 flag after reset", {7'd0, irq_flag}, 8'h00);
    check("R1 rdata after reset", rdata, 8'h00);
    rd(2'd0, rv); check("R1 counter low", rv, 8'hFF);
    rd(2'd1, rv); check("R1 counter high", rv, 8'hFF);
    rd(2'd2, rv); check("R1 latch low", rv, 8'hFF);
    rd(2'd3, rv); check("R1 latch high", rv, 8'hFF);

    for (int i = 0; i < 11; i++) begin
      if (VEC[i][10]) wr(VEC[i][9:8], VEC[i][7:0]);
      else begin
        rd(VEC[i][9:8], rv);
        check($sformatf("vector %0d (R2/R3/R4/R9)", i), rv, VEC[i][7:0]);
      end
    end

    // free-running period with latch 5
    wr(2'd2, 8'h05); wr(2'd1, 8'h00);
    check("R3 flag clear after load", {7'd0, irq_flag}, 8'h00);
    ticks(4); check("R7 no flag before zero", {7'd0, irq_flag}, 8'h00);
    ticks(1); check("R7 flag at zero", {7'd0, irq_flag}, 8'h01);
    rd(2'd1, rv); check("R9 counter high at zero", rv, 8'h00);
    check("R9 high read keeps flag", {7'd0, irq_flag}, 8'h01);
    rd(2'd0, rv); check("R9 counter low at zero", rv, 8'h00);
    check("R9 low read clears flag", {7'd0, irq_flag}, 8'h00);
    ticks(1); rd(2'd1, rv); check("R5 wrap high", rv, 8'hFF);
    rd(2'd0, rv); check("R5 wrap low", rv, 8'hFF);
    ticks(1); rd(2'd0, rv); check("R5 reload from latch", rv, 8'h05);
    ticks(4); check("R7 no flag at latch+1", {7'd0, irq_flag}, 8'h00);
    ticks(1); check("R7 flag again after latch+2", {7'd0, irq_flag}, 8'h01);
    wr(2'd3, 8'h00);
    check("R4 latch high write clears flag", {7'd0, irq_flag}, 8'h00);
    rd(2'd0, rv); check("R4 counter kept", rv, 8'h00);
    repeat (20) @(negedge clk);
    rd(2'd0, rv); check("R6 hold without tick", rv, 8'h00);

    // one-shot
    @(negedge clk); free_run = 1'b0;
    wr(2'd2, 8'h04); wr(2'd1, 8'h00);
    ticks(4); check("R8 first zero flags", {7'd0, irq_flag}, 8'h01);
    rd(2'd0, rv); check("R8 clear via low read", {7'd0, irq_flag}, 8'h00);
    ticks(6); check("R8 second zero silent", {7'd0, irq_flag}, 8'h00);
    rd(2'd0, rv); check("R8 counter back at zero", rv, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule